// File: doc/BRIEF.md
# Four-Phase Subtract Execute Unit

This unit decodes and carries out the two 8-bit subtract instructions of a small accumulator-style processor core. In both, the working register is the subtrahend. In the literal form the minuend is an 8-bit immediate taken from the instruction word. In the register form the minuend is a byte read from the register file. The register form can send its result back to the register file or to the working register. It builds its 12-bit data address either from the bank register or from the fixed access-bank map.

Every instruction takes one instruction cycle of four clock phases, and the unit produces the phase number itself. In the first phase the unit takes the instruction word, the working register and the bank register. In the second phase it reads the register-file operand. The third phase computes the difference and the five status flags. The fourth phase drives the write strobes, the result and the new flags. Fetch and the rest of the instruction set sit outside this unit. Every other opcode passes through its four phases with no effect.

Top module: `sub_exec_unit`

## Requirements
- R1: `phase_o` is 0 in the first cycle after reset. It then counts 0, 1, 2, 3 once per clock and wraps to 0. Phase 0 is decode, 1 is read, 2 is process and 3 is write.
- R2: An instruction word whose upper byte is 08h is the literal form. Its result is low byte minus working register, modulo 256. It raises `wreg_we`, never `rf_we`, and never raises `rf_re`.
- R3: An instruction word whose bits [15:10] are 010111 is the register form. It raises `rf_re` for phase 1 only, with the operand address on `rf_raddr`. Its result is the operand minus the working register, modulo 256.
- R4: In the register form, bit 9 is the destination select. 0 raises `wreg_we`. 1 raises `rf_we`, with `rf_waddr` equal to the read address. The two strobes are never high together.
- R5: In the register form, bit 8 selects the bank. 1 gives the address {`bsr_in`, instr[7:0]}. 0 gives {0h, instr[7:0]} for instr[7:0] < 80h, and {Fh, instr[7:0]} otherwise.
- R6: `flags_o` is {N, OV, Z, DC, C} from bit 4 down to bit 0. C is 1 when the minuend is at least the subtrahend as unsigned numbers. DC is 1 when the minuend's low nibble is at least the subtrahend's low nibble.
- R7: N equals bit 7 of the result. Z is 1 exactly when the result is 00h.
- R8: OV is 1 when the minuend and the subtrahend differ in bit 7 and the result's bit 7 differs from the minuend's bit 7.
- R9: Any other instruction word raises no strobe, including `rf_re`, and leaves `flags_o` unchanged.
- R10: `wreg_we`, `rf_we` and `flags_we` are high only during phase 3, for one cycle. `flags_o` changes only on the edge that raises `flags_we`. After reset the flags are 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_in | input | 16 | Instruction word, sampled at the end of phase 0 |
| wreg_in | input | 8 | Working register value, sampled at the end of phase 0 |
| bsr_in | input | 4 | Bank register, sampled at the end of phase 0 |
| phase_o | output | 2 | Current phase, 0 to 3 |
| rf_re | output | 1 | Register-file read strobe (phase 1) |
| rf_raddr | output | 12 | Register-file read address |
| rf_rdata | input | 8 | Read data, valid during phase 1 |
| rf_we | output | 1 | Register-file write strobe (phase 3) |
| rf_waddr | output | 12 | Register-file write address |
| result_o | output | 8 | Difference, valid while a write strobe is high |
| wreg_we | output | 1 | Working-register write strobe (phase 3) |
| flags_we | output | 1 | Flag update strobe (phase 3) |
| flags_o | output | 5 | Status flags {N, OV, Z, DC, C} |

## Verification
The bench starts with directed cases for the flag boundaries: 2−1, 2−2 and 2−3, 80h−01h for signed overflow, and 10h−01h for a nibble borrow. A design that inverted the borrow sense would report C=0 on the 2−1 case. A design that took OV from the result alone would miss the 80h−01h case. Directed register-form cases use f = 05h and f = 85h, with both values of the bank-select bit. A design that mapped the access bank wrongly would read and write the wrong byte, and the bench sees this in the model register file. After that, random literal, register and non-subtract words run with fixed flag, working-register and register-file models. A design that let a non-subtract word raise a strobe, or change the flags, would show the difference at phase 3.

// File: rtl/sub_exec_pkg.sv
package sub_exec_pkg;
  typedef enum logic [1:0] {PH_DEC = 2'd0, PH_READ = 2'd1, PH_PROC = 2'd2, PH_WRITE = 2'd3} phase_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

  typedef struct packed {
    logic        is_lit;
    logic        is_reg;
    logic        to_file;
    logic [11:0] addr;
    logic [7:0]  imm;
  } decoded_t;
endpackage

// File: rtl/sub_phase_seq.sv
module sub_phase_seq
  import sub_exec_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_DEC;
    else     phase <= phase_e'(phase + 2'd1);
  end
endmodule

// File: rtl/sub_decode.sv
module sub_decode
  import sub_exec_pkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int FADDR_W = 8,
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [BANK_W-1:0]  bank,
  output decoded_t           dec
);
  localparam logic [7:0] LIT_OP = 8'h08;
  localparam logic [5:0] REG_OP = 6'b010111;
  localparam logic [BANK_W-1:0] LOW_BANK  = '0;
  localparam logic [BANK_W-1:0] HIGH_BANK = '1;

  logic [FADDR_W-1:0] f;
  logic [BANK_W-1:0]  sel_bank;

  always_comb begin
    f        = instr[FADDR_W-1:0];
    // bit 8: 1 = bank register, 0 = access-bank split on f's top bit
    if (instr[8]) sel_bank = bank;
    else          sel_bank = f[FADDR_W-1] ? HIGH_BANK : LOW_BANK;
    dec         = '0;
    dec.is_lit  = (instr[15:8] == LIT_OP);
    dec.is_reg  = (instr[15:10] == REG_OP);
    dec.to_file = dec.is_reg & instr[9];
    dec.addr    = {sel_bank, f};
    dec.imm     = instr[7:0];
  end
endmodule

// File: rtl/sub_alu.sv
module sub_alu
  import sub_exec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  output logic [DATA_W-1:0] diff,
  output flags_t            flags
);
  localparam int NIB = 4;

  logic [DATA_W:0] wide;

  always_comb begin
    wide     = {1'b0, minuend} - {1'b0, subtrahend};
    diff     = wide[DATA_W-1:0];
    flags.c  = ~wide[DATA_W];
    flags.dc = (minuend[NIB-1:0] >= subtrahend[NIB-1:0]);
    flags.n  = diff[DATA_W-1];
    flags.z  = (diff == '0);
    flags.ov = (minuend[DATA_W-1] != subtrahend[DATA_W-1]) &&
               (diff[DATA_W-1] != minuend[DATA_W-1]);
  end
endmodule

// File: rtl/sub_exec_unit.sv
module sub_exec_unit
  import sub_exec_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 4,
  parameter int FADDR_W = 8,
  parameter int INSTR_W = 16,
  localparam int ADDR_W = BANK_W + FADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_in,
  input  logic [DATA_W-1:0]  wreg_in,
  input  logic [BANK_W-1:0]  bsr_in,
  output logic [1:0]         phase_o,
  output logic               rf_re,
  output logic [ADDR_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0]  rf_rdata,
  output logic               rf_we,
  output logic [ADDR_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0]  result_o,
  output logic               wreg_we,
  output logic               flags_we,
  output logic [4:0]         flags_o
);
  phase_e      ph;
  decoded_t    dec, dec_q;
  logic [DATA_W-1:0] w_q, opnd_q, alu_diff;
  flags_t      alu_flags, flags_q;
  logic        re_q, rf_we_q, wreg_we_q, flags_we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] result_q;

  sub_phase_seq u_seq (.clk(clk), .rst(rst), .phase(ph));

  sub_decode #(.BANK_W(BANK_W), .FADDR_W(FADDR_W), .INSTR_W(INSTR_W)) u_dec (
    .instr(instr_in), .bank(bsr_in), .dec(dec));

  sub_alu #(.DATA_W(DATA_W)) u_alu (
    .minuend(opnd_q), .subtrahend(w_q), .diff(alu_diff), .flags(alu_flags));

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q      <= '0;
      w_q        <= '0;
      opnd_q     <= '0;
      re_q       <= 1'b0;
      addr_q     <= '0;
      result_q   <= '0;
      flags_q    <= '0;
      rf_we_q    <= 1'b0;
      wreg_we_q  <= 1'b0;
      flags_we_q <= 1'b0;
    end else begin
      case (ph)
        PH_DEC: begin
          dec_q  <= dec;
          w_q    <= wreg_in;
          addr_q <= dec.addr;
          re_q   <= dec.is_reg;
        end
        PH_READ: begin
          re_q   <= 1'b0;
          opnd_q <= dec_q.is_reg ? rf_rdata : dec_q.imm;
        end
        PH_PROC: begin
          if (dec_q.is_lit || dec_q.is_reg) begin
            result_q   <= alu_diff;
            flags_q    <= alu_flags;
            flags_we_q <= 1'b1;
            rf_we_q    <= dec_q.to_file;
            wreg_we_q  <= ~dec_q.to_file;
          end
        end
        default: begin
          rf_we_q    <= 1'b0;
          wreg_we_q  <= 1'b0;
          flags_we_q <= 1'b0;
        end
      endcase
    end
  end

  assign phase_o  = ph;
  assign rf_re    = re_q;
  assign rf_raddr = addr_q;
  assign rf_waddr = addr_q;
  assign rf_we    = rf_we_q;
  assign wreg_we  = wreg_we_q;
  assign flags_we = flags_we_q;
  assign result_o = result_q;
  assign flags_o  = flags_q;
endmodule

// File: rtl/sub_exec_chk.sv
module sub_exec_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] phase_o,
  input logic       rf_re,
  input logic       rf_we,
  input logic       wreg_we,
  input logic       flags_we,
  input logic [7:0] result_o,
  input logic [4:0] flags_o
);
  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 2'd3) |=> (phase_o == 2'd0));
  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o != 2'd3) |=> (phase_o == $past(phase_o) + 2'd1));
  // R3
  read_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rf_re |-> (phase_o == 2'd1));
  // R4
  single_dest_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf_we, wreg_we}));
  // R10
  strobe_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we || wreg_we || flags_we) |-> (phase_o == 2'd3));
  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(flags_o) |-> flags_we);
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_o[2] == (result_o == 8'h00)));
  // R7
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_o[4] == result_o[7]));
endmodule

bind sub_exec_unit sub_exec_chk i_chk (
  .clk(clk), .rst(rst), .phase_o(phase_o), .rf_re(rf_re), .rf_we(rf_we),
  .wreg_we(wreg_we), .flags_we(flags_we), .result_o(result_o), .flags_o(flags_o));

// File: tb/test_sub_exec_unit.sv
module test_sub_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_in = '0;
  logic [7:0]  wreg_in = '0;
  logic [3:0]  bsr_in = '0;
  logic [1:0]  phase_o;
  logic        rf_re, rf_we, wreg_we, flags_we;
  logic [11:0] rf_raddr, rf_waddr;
  logic [7:0]  rf_rdata, result_o;
  logic [4:0]  flags_o;

  logic [7:0] mem [4096];
  logic [7:0] w_m;
  logic [4:0] fl_m;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  assign rf_rdata = mem[rf_raddr];

  sub_exec_unit i_sub_exec_unit (
    .clk(clk), .rst(rst), .instr_in(instr_in), .wreg_in(wreg_in), .bsr_in(bsr_in),
    .phase_o(phase_o), .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .result_o(result_o), .wreg_we(wreg_we),
    .flags_we(flags_we), .flags_o(flags_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] addr_of(input logic [15:0] ins, input logic [3:0] b);
    if (ins[8]) return {b, ins[7:0]};
    return {(ins[7] ? 4'hF : 4'h0), ins[7:0]};
  endfunction

  function automatic logic [4:0] flags_of(input logic [7:0] m, input logic [7:0] s);
    logic [7:0] r;
    r = m - s;
    return {r[7], (m[7] != s[7]) && (r[7] != m[7]), r == 8'h00,
            m[3:0] >= s[3:0], m >= s};
  endfunction

  // Runs one instruction from phase 0 to phase 3 and checks it
  task automatic run(input logic [15:0] ins, input logic [3:0] b);
    logic lit, regf, tofile;
    logic [11:0] a;
    logic [7:0] m, r;
    logic [4:0] f;
    lit    = (ins[15:8] == 8'h08);
    regf   = (ins[15:10] == 6'b010111);
    tofile = regf & ins[9];
    a      = addr_of(ins, b);
    check("R1 phase0", {30'd0, phase_o}, 32'd0);
    instr_in = ins; wreg_in = w_m; bsr_in = b;
    @(negedge clk);
    check(regf ? "R3 read strobe" : "R9 no read", {31'd0, rf_re}, {31'd0, regf});
    if (regf) check("R5 read address", {20'd0, rf_raddr}, {20'd0, a});
    m = regf ? mem[a] : ins[7:0];
    r = m - w_m;
    f = flags_of(m, w_m);
    @(negedge clk);
    check("R10 quiet in phase2", {29'd0, rf_we, wreg_we, flags_we}, 32'd0);
    @(negedge clk);
    check("R1 phase3", {30'd0, phase_o}, 32'd3);
    if (lit || regf) begin
      check(lit ? "R2 literal dest" : "R4 dest select",
            {30'd0, rf_we, wreg_we}, {30'd0, tofile, ~tofile});
      check(lit ? "R2 literal result" : "R3 register result", {24'd0, result_o}, {24'd0, r});
      check("R6 R8 flags", {27'd0, flags_o}, {27'd0, f});
      check("R7 N Z", {30'd0, flags_o[4], flags_o[2]}, {30'd0, r[7], r == 8'h00});
      check("R10 flag strobe", {31'd0, flags_we}, 32'd1);
      if (tofile) begin
        check("R4 write address", {20'd0, rf_waddr}, {20'd0, a});
        mem[a] = r;
      end else w_m = r;
      fl_m = f;
    end else begin
      check("R9 no strobes", {29'd0, rf_we, wreg_we, flags_we}, 32'd0);
      check("R9 flags kept", {27'd0, flags_o}, {27'd0, fl_m});
    end
    @(negedge clk);
    check("R10 strobes end", {29'd0, rf_we, wreg_we, flags_we}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    w_m = 8'h00; fl_m = 5'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R10 reset flags", {27'd0, flags_o}, 32'd0);
    check("R10 reset strobes", {28'd0, rf_re, rf_we, wreg_we, flags_we}, 32'd0);
    check("R1 reset phase", {30'd0, phase_o}, 32'd1);
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R2 R6 R7 directed: 2-1, 2-2, 2-3
    w_m = 8'h01; run(16'h0802, 4'h0);
    w_m = 8'h02; run(16'h0802, 4'h0);
    w_m = 8'h03; run(16'h0802, 4'h0);
    // R8 overflow, R6 nibble borrow
    w_m = 8'h01; run(16'h0880, 4'h0);
    w_m = 8'h01; run(16'h0810, 4'h0);
    // R5 access bank low/high, bank register; R4 both destinations
    w_m = 8'h11; run(16'h5C05, 4'h3);
    w_m = 8'h22; run(16'h5E85, 4'h3);
    w_m = 8'h33; run(16'h5D85, 4'h3);
    w_m = 8'h44; run(16'h5F05, 4'h9);
    // R9 near-miss opcodes
    run(16'h5805, 4'h1);
    run(16'h0905, 4'h1);
    for (int i = 0; i < 300; i++) begin
      logic [15:0] ins;
      int k;
      k = int'($urandom % 3);
      w_m = 8'($urandom);
      ins = 16'($urandom);
      if (k == 0) ins[15:8] = 8'h08;
      else if (k == 1) ins[15:10] = 6'b010111;
      else if (ins[15:8] == 8'h08 || ins[15:10] == 6'b010111) ins[15] = 1'b1;
      run(ins, 4'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule